// File: doc/BRIEF.md
# Function Configuration Header Register File

This block holds the 64-byte standard configuration header of one bus function: fixed identity fields, the command and status words, three writable byte registers, and six base address registers (BARs). A single request stream carries an offset, an access size of 1, 2 or 4 bytes, a write flag and write data. Each accepted request produces exactly one response that carries read data and an error flag.

Each register has its own write rule. A write that the rule does not allow is accepted but leaves the stored state unchanged. The BARs are sized by parameters. A write of all ones to a BAR returns its size mask on the next read. Any other write stores the address with the bits below the BAR size cleared. The type bits at the bottom of each BAR are read-only. When a normal BAR write leaves a nonzero base address, the block reports that base on a one-cycle strobe so that a neighbouring address decoder can take it up.

Both sides of the request port use valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its response appears on the next cycle. A response that is not taken holds the port: `req_ready` stays low until `rsp_ready` is seen.

Top module: `pci_cfg_space`

## Requirements
- R1: An access with offset 0x40 or above returns `rsp_err`=1 and `rsp_rdata`=0, and changes no register.
- R2: A size other than 1, 2 or 4 returns an error, and so does an access that is not aligned to its size (a 2-byte access at an odd offset, a 4-byte access with offset[1:0] not zero). Such an access changes no register.
- R3: A legal read returns the stored bytes in little-endian order, placed at bit 0 and zero-extended to 32 bits. The layout is: vendor identifier at 0x00-0x01, device identifier at 0x02-0x03, revision at 0x08, class code at 0x09-0x0B, header type at 0x0E, interrupt pin at 0x3D. All of these are read-only parameters. Every byte not named in R3 to R6 reads as zero.
- R4: A 1-byte write takes `req_wdata[7:0]` and is stored only at 0x0C (cache line size), 0x0D (latency timer) and 0x3C (interrupt line). A 1-byte write at any other offset is ignored.
- R5: A 2-byte write takes `req_wdata[15:0]` and is stored only at 0x04 (command) and 0x06 (status). A 2-byte write at any other offset is ignored.
- R6: BAR n (n = 0 to 5) sits at 0x10+4n and takes only 4-byte writes. For a BAR of size S, the stored value is (wdata & ~(S-1)) with the read-only type bits put back. An I/O BAR keeps bits[1:0]=01. A memory BAR keeps bits[3:0]=0000. A write of 0xFFFFFFFF therefore reads back as ~(S-1) with the type bits.
- R7: A BAR write whose data is not all ones, and whose stored value with bit 0 cleared is nonzero, raises `bar_map_valid` for one cycle together with its response. In that cycle `bar_map_idx` is n and `bar_map_base` is the stored value with bit 0 cleared. A sizing write, or a write that leaves a zero base, raises no strobe.
- R8: A 4-byte write at any offset that is not a BAR is ignored.
- R9: `req_ready` equals `!rsp_valid || rsp_ready`. The response is valid on the cycle after acceptance. While `rsp_valid` is high and `rsp_ready` is low, the response data and the error flag stay unchanged.
- R10: After reset, command, status, cache line size, latency timer and interrupt line read as zero, and each BAR reads as its type bits only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 8 | Byte offset into the header |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, placed at bit 0 |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |
| rsp_err | output | 1 | Request rejected |
| bar_map_valid | output | 1 | A BAR received a new base address |
| bar_map_idx | output | 3 | Index of that BAR |
| bar_map_base | output | 32 | Decoded base address |

## Verification
The main function is swept over every offset in the header three times: with byte reads, aligned 2-byte reads and aligned 4-byte reads. It is swept again after byte, word and dword writes have gone to every offset. This separates the registers that take a write from those that must ignore one, and it shows any lane or endianness error in the read path. The BARs are tried with three kinds of data on each of the six sizes and both types. All-ones data checks the sizing mask. An arbitrary address checks masking and the strobe. Zero data checks that no strobe is raised. All offsets from 0x40 to 0xFF, every illegal size and every misaligned position are probed for the error flag. A held response checks that back-pressure keeps the response stable.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
  localparam int HDR_BYTES = 64;
  localparam int NUM_BARS  = 6;
  localparam int BAR_FIRST_DW = 4;  // dword index of BAR0 (offset 0x10)

  localparam logic [5:0] OFS_CMD   = 6'h04;
  localparam logic [5:0] OFS_STS   = 6'h06;
  localparam logic [5:0] OFS_CLS   = 6'h0C;
  localparam logic [5:0] OFS_LAT   = 6'h0D;
  localparam logic [5:0] OFS_INTL  = 6'h3C;

  typedef enum logic [2:0] {
    SZ_BYTE  = 3'd1,
    SZ_WORD  = 3'd2,
    SZ_DWORD = 3'd4
  } acc_size_e;

  typedef struct packed {
    logic [15:0] cmd;
    logic [15:0] sts;
    logic [7:0]  cls;
    logic [7:0]  lat;
    logic [7:0]  intl;
  } hdr_rw_t;

  function automatic logic size_ok(input logic [2:0] sz);
    return (sz == SZ_BYTE) || (sz == SZ_WORD) || (sz == SZ_DWORD);
  endfunction

  function automatic logic align_ok(input logic [2:0] sz, input logic [1:0] lo);
    case (sz)
      SZ_WORD:  return lo[0] == 1'b0;
      SZ_DWORD: return lo == 2'b00;
      default:  return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/pci_cfg_bar.sv
module pci_cfg_bar #(
  parameter int SIZE_LOG2 = 4,
  parameter bit IS_IO     = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] value,
  output logic        map_fire,
  output logic [31:0] map_base
);
  localparam logic [31:0] ADDR_MASK = ~((32'd1 << SIZE_LOG2) - 32'd1);
  localparam logic [31:0] RO_MASK   = IS_IO ? 32'h0000_0003 : 32'h0000_000F;
  localparam logic [31:0] TYPE_BITS = IS_IO ? 32'h0000_0001 : 32'h0000_0000;

  logic [31:0] next_val;
  logic [31:0] next_base;
  logic        sizing;

  always_comb begin
    next_val  = (wdata & ADDR_MASK & ~RO_MASK) | TYPE_BITS;
    next_base = next_val & ~32'h1;
    sizing    = &wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value    <= TYPE_BITS;
      map_fire <= 1'b0;
      map_base <= '0;
    end else begin
      map_fire <= wr_en && !sizing && (next_base != 32'd0);
      if (wr_en) begin
        value    <= next_val;
        map_base <= next_base;
      end
    end
  end
endmodule

// File: rtl/pci_cfg_hdr_regs.sv
module pci_cfg_hdr_regs
  import pci_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [5:0]  ofs,
  input  logic [2:0]  sz,
  input  logic [15:0] wd,
  output hdr_rw_t     regs
);
  logic byte_wr, word_wr;

  always_comb begin
    byte_wr = wr_en && (sz == SZ_BYTE);
    word_wr = wr_en && (sz == SZ_WORD);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs <= '0;
    end else begin
      if (byte_wr && ofs == OFS_CLS)  regs.cls  <= wd[7:0];
      if (byte_wr && ofs == OFS_LAT)  regs.lat  <= wd[7:0];
      if (byte_wr && ofs == OFS_INTL) regs.intl <= wd[7:0];
      if (word_wr && ofs == OFS_CMD)  regs.cmd  <= wd;
      if (word_wr && ofs == OFS_STS)  regs.sts  <= wd;
    end
  end
endmodule

// File: rtl/pci_cfg_rd_mux.sv
module pci_cfg_rd_mux
  import pci_cfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h0000,
  parameter logic [15:0] DEVICE_ID = 16'h0000,
  parameter logic [7:0]  REV_ID    = 8'h00,
  parameter logic [23:0] CLASS_CODE = 24'h000000,
  parameter logic [7:0]  HDR_TYPE  = 8'h00,
  parameter logic [7:0]  INT_PIN   = 8'h00
) (
  input  logic [5:0]                   ofs,
  input  logic [2:0]                   sz,
  input  hdr_rw_t                      regs,
  input  logic [NUM_BARS-1:0][31:0]    bars,
  output logic [31:0]                  rdata
);
  logic [31:0] dword;
  logic [31:0] shifted;
  logic [3:0]  dw_idx;

  always_comb begin
    dw_idx = ofs[5:2];
    dword  = '0;
    case (dw_idx)
      4'd0:  dword = {DEVICE_ID, VENDOR_ID};
      4'd1:  dword = {regs.sts, regs.cmd};
      4'd2:  dword = {CLASS_CODE, REV_ID};
      4'd3:  dword = {8'h00, HDR_TYPE, regs.lat, regs.cls};
      4'd15: dword = {16'h0000, INT_PIN, regs.intl};
      default: begin
        for (int i = 0; i < NUM_BARS; i++)
          if (dw_idx == 4'(BAR_FIRST_DW + i)) dword = bars[i];
      end
    endcase
    shifted = dword >> {ofs[1:0], 3'b000};
    case (sz)
      SZ_BYTE: rdata = {24'h0, shifted[7:0]};
      SZ_WORD: rdata = {16'h0, shifted[15:0]};
      default: rdata = shifted;
    endcase
  end
endmodule

// File: rtl/pci_cfg_space.sv
module pci_cfg_space
  import pci_cfg_pkg::*;
#(
  parameter int OFS_W = 8,
  parameter logic [15:0] VENDOR_ID  = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID  = 16'hB00F,
  parameter logic [7:0]  REV_ID     = 8'h03,
  parameter logic [23:0] CLASS_CODE = 24'h058000,
  parameter logic [7:0]  HDR_TYPE   = 8'h00,
  parameter logic [7:0]  INT_PIN    = 8'h01,
  parameter logic [NUM_BARS-1:0]   BAR_IS_IO   = 6'b010001,
  parameter logic [NUM_BARS*5-1:0] BAR_SZ_LOG2 =
    {5'd16, 5'd8, 5'd4, 5'd20, 5'd12, 5'd5}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [OFS_W-1:0] req_offset,
  input  logic [2:0]       req_size,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [31:0]      rsp_rdata,
  output logic             rsp_err,
  output logic             bar_map_valid,
  output logic [2:0]       bar_map_idx,
  output logic [31:0]      bar_map_base
);
  localparam logic [OFS_W-1:0] OFS_LIMIT = OFS_W'(HDR_BYTES);

  logic                       accept, legal, wr_ok;
  logic [5:0]                 ofs6;
  logic [31:0]                rd_val;
  hdr_rw_t                    hdr;
  logic [NUM_BARS-1:0][31:0]  bar_val;
  logic [NUM_BARS-1:0][31:0]  bar_base;
  logic [NUM_BARS-1:0]        bar_fire;
  logic [NUM_BARS-1:0]        bar_wr;

  always_comb begin
    req_ready = !rsp_valid || rsp_ready;
    accept    = req_valid && req_ready;
    ofs6      = req_offset[5:0];
    legal     = (req_offset < OFS_LIMIT) && size_ok(req_size) &&
                align_ok(req_size, req_offset[1:0]);
    wr_ok     = accept && req_write && legal;
  end

  pci_cfg_hdr_regs u_hdr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_ok),
    .ofs   (ofs6),
    .sz    (req_size),
    .wd    (req_wdata[15:0]),
    .regs  (hdr)
  );

  for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
    assign bar_wr[g] = wr_ok && (req_size == SZ_DWORD) &&
                       (ofs6[5:2] == 4'(BAR_FIRST_DW + g));
    pci_cfg_bar #(
      .SIZE_LOG2 (int'(BAR_SZ_LOG2[g*5 +: 5])),
      .IS_IO     (BAR_IS_IO[g])
    ) u_bar (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bar_wr[g]),
      .wdata    (req_wdata),
      .value    (bar_val[g]),
      .map_fire (bar_fire[g]),
      .map_base (bar_base[g])
    );
  end

  pci_cfg_rd_mux #(
    .VENDOR_ID  (VENDOR_ID),
    .DEVICE_ID  (DEVICE_ID),
    .REV_ID     (REV_ID),
    .CLASS_CODE (CLASS_CODE),
    .HDR_TYPE   (HDR_TYPE),
    .INT_PIN    (INT_PIN)
  ) u_rd (
    .ofs   (ofs6),
    .sz    (req_size),
    .regs  (hdr),
    .bars  (bar_val),
    .rdata (rd_val)
  );

  always_comb begin
    bar_map_valid = |bar_fire;
    bar_map_idx   = '0;
    bar_map_base  = '0;
    for (int i = 0; i < NUM_BARS; i++) begin
      if (bar_fire[i]) begin
        bar_map_idx  = 3'(i);
        bar_map_base = bar_base[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_err   <= !legal;
      rsp_rdata <= (legal && !req_write) ? rd_val : 32'd0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pci_cfg_space_chk.sv
module pci_cfg_space_chk #(
  parameter int OFS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic [OFS_W-1:0] req_offset,
  input logic [2:0]       req_size,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [31:0]      rsp_rdata,
  input logic             rsp_err,
  input logic             bar_map_valid,
  input logic [2:0]       bar_map_idx,
  input logic [31:0]      bar_map_base
);
  p_high_ofs_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_offset >= OFS_W'(64)) |=> (rsp_valid && rsp_err));

  p_err_no_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == 32'd0));

  p_bad_size_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_size != 3'd1 && req_size != 3'd2 && req_size != 3'd4)
    |=> (rsp_valid && rsp_err));

  p_byte_read_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && req_size == 3'd1)
    |=> (rsp_rdata[31:8] == 24'd0));

  p_map_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bar_map_valid |-> (bar_map_base != 32'd0 && !bar_map_base[0] && bar_map_idx < 3'd6));

  p_map_from_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !(req_write && req_size == 3'd4)) |=> !bar_map_valid);

  p_rsp_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));
endmodule

bind pci_cfg_space pci_cfg_space_chk #(.OFS_W(OFS_W)) u_chk (.*);

// File: tb/pci_cfg_space_bench.sv
module pci_cfg_space_bench;
  localparam logic [15:0] VEN = 16'hC0DE;
  localparam logic [15:0] DEV = 16'hB00F;
  localparam logic [7:0]  REV = 8'h03;
  localparam logic [23:0] CLS = 24'h058000;
  localparam logic [7:0]  HDT = 8'h00;
  localparam logic [7:0]  PIN = 8'h01;
  localparam logic [5:0]  IO_MAP = 6'b010001;
  localparam logic [29:0] LOG2S  = {5'd16, 5'd8, 5'd4, 5'd20, 5'd12, 5'd5};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [7:0]  req_offset = '0;
  logic [2:0]  req_size = 3'd4;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, bar_map_valid;
  logic [31:0] rsp_rdata, bar_map_base;
  logic [2:0]  bar_map_idx;

  always #5 clk = ~clk;

  pci_cfg_space #(
    .VENDOR_ID(VEN), .DEVICE_ID(DEV), .REV_ID(REV), .CLASS_CODE(CLS),
    .HDR_TYPE(HDT), .INT_PIN(PIN), .BAR_IS_IO(IO_MAP), .BAR_SZ_LOG2(LOG2S)
  ) u_pci_cfg_space (.*);

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] mdl [64];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mdl_read(input int o, input int sz);
    logic [31:0] r = '0;
    for (int k = 0; k < sz; k++) r = r | (32'(mdl[o+k]) << (8*k));
    return r;
  endfunction

  function automatic logic [31:0] bar_type(input int n);
    return IO_MAP[n] ? 32'h1 : 32'h0;
  endfunction

  task automatic mdl_reset();
    for (int i = 0; i < 64; i++) mdl[i] = 8'h00;
    {mdl[1], mdl[0]} = VEN;
    {mdl[3], mdl[2]} = DEV;
    mdl[8] = REV;
    {mdl[11], mdl[10], mdl[9]} = CLS;
    mdl[14] = HDT;
    mdl[61] = PIN;
    for (int n = 0; n < 6; n++) mdl[16+4*n] = bar_type(n)[7:0];
  endtask

  // model of a legal write; returns the expected strobe
  task automatic mdl_write(input int o, input int sz, input logic [31:0] wd,
                           output bit mv, output logic [2:0] mi, output logic [31:0] mb);
    mv = 0; mi = '0; mb = '0;
    if (sz == 1 && (o == 12 || o == 13 || o == 60)) mdl[o] = wd[7:0];
    if (sz == 2 && (o == 4 || o == 6)) {mdl[o+1], mdl[o]} = wd[15:0];
    if (sz == 4 && o >= 16 && o < 40) begin
      int n = (o - 16) / 4;
      logic [31:0] sizev = 32'd1 << LOG2S[n*5 +: 5];
      logic [31:0] lowm = IO_MAP[n] ? 32'h3 : 32'hF;
      logic [31:0] v = (wd & ~(sizev - 1) & ~lowm) | bar_type(n);
      {mdl[o+3], mdl[o+2], mdl[o+1], mdl[o]} = v;
      if (wd != 32'hFFFF_FFFF && (v & ~32'h1) != 0) begin
        mv = 1; mi = 3'(n); mb = v & ~32'h1;
      end
    end
  endtask

  task automatic xfer(input bit wr, input logic [7:0] ofs, input logic [2:0] sz,
                      input logic [31:0] wd, output logic [31:0] rd, output logic er,
                      output logic mv, output logic [2:0] mi, output logic [31:0] mb);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_offset = ofs; req_size = sz; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid === 1'b1, "R9 response valid after accept", 32'(rsp_valid), 32'd1);
    rd = rsp_rdata; er = rsp_err; mv = bar_map_valid; mi = bar_map_idx; mb = bar_map_base;
  endtask

  task automatic rd_check(input int o, input int sz, input string req);
    logic [31:0] rd, mb; logic er, mv; logic [2:0] mi;
    xfer(0, 8'(o), 3'(sz), 32'd0, rd, er, mv, mi, mb);
    chk(!er && rd === mdl_read(o, sz), req, rd, mdl_read(o, sz));
  endtask

  task automatic sweep(input string req);
    for (int o = 0; o < 64; o++) rd_check(o, 1, req);
    for (int o = 0; o < 64; o += 2) rd_check(o, 2, req);
    for (int o = 0; o < 64; o += 4) rd_check(o, 4, req);
  endtask

  task automatic wr_check(input int o, input int sz, input logic [31:0] wd, input string req);
    logic [31:0] rd, mb, eb; logic er, mv, emv; logic [2:0] mi, ei;
    mdl_write(o, sz, wd, emv, ei, eb);
    xfer(1, 8'(o), 3'(sz), wd, rd, er, mv, mi, mb);
    chk(!er && rd == 32'd0, req, {31'd0, er}, 32'd0);
    chk(mv === emv, "R7 strobe presence", 32'(mv), 32'(emv));
    if (emv) chk(mi === ei && mb === eb, "R7 strobe index/base", {mi, mb[28:0]}, {ei, eb[28:0]});
  endtask

  task automatic err_check(input bit wr, input int o, input int sz, input string req);
    logic [31:0] rd, mb; logic er, mv; logic [2:0] mi;
    xfer(wr, 8'(o), 3'(sz), 32'hFFFF_FFFF, rd, er, mv, mi, mb);
    chk(er === 1'b1 && rd === 32'd0 && !mv, req, rd, 32'd0);
  endtask

  initial begin
    mdl_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    chk(rsp_valid === 0 && req_ready === 1, "R10 reset handshake state", 32'(rsp_valid), 32'd0);
    sweep("R10 R3 reset contents");

    // byte writes everywhere (R4)
    for (int o = 0; o < 64; o++) wr_check(o, 1, 32'(o ^ 8'hA5), "R4 byte write accepted");
    sweep("R4 after byte writes");
    // word writes everywhere (R5)
    for (int o = 0; o < 64; o += 2) wr_check(o, 2, 32'({8'(o), 8'(~o)}), "R5 word write accepted");
    sweep("R5 after word writes");
    // dword writes on non-BAR offsets (R8)
    for (int o = 0; o < 64; o += 4)
      if (o < 16 || o >= 40) wr_check(o, 4, 32'h5A5A_0000 | 32'(o), "R8 dword write accepted");
    sweep("R8 after non-BAR dword writes");

    // BARs (R6 R7)
    for (int n = 0; n < 6; n++) begin
      int o = 16 + 4*n;
      wr_check(o, 4, 32'hFFFF_FFFF, "R6 sizing write");
      rd_check(o, 4, "R6 sizing readback");
      wr_check(o, 4, 32'h1234_5679 + 32'(n * 32'h0101_0000), "R6 address write");
      rd_check(o, 4, "R6 address readback");
      rd_check(o + 1, 1, "R6 byte read of BAR");
      wr_check(o, 4, 32'd0, "R7 zero write");
      rd_check(o, 4, "R6 zero readback");
      wr_check(o, 4, 32'h8000_0000, "R7 high address");
    end
    sweep("R6 after BAR writes");

    // errors (R1 R2)
    for (int o = 64; o < 256; o++) err_check(o[0], o, 4 >> (o % 3), "R1 high offset error");
    for (int s = 0; s < 8; s++)
      if (s != 1 && s != 2 && s != 4) err_check(s[0], 12, s, "R2 illegal size");
    for (int o = 1; o < 64; o += 2) err_check(1, o, 2, "R2 misaligned word");
    for (int o = 0; o < 64; o++) if (o % 4 != 0) err_check(1, o, 4, "R2 misaligned dword");
    sweep("R1 R2 state unchanged after errors");

    // back-pressure (R9)
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_write = 0; req_offset = 8'd0; req_size = 3'd4;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid === 1 && req_ready === 0, "R9 stall blocks request", 32'(req_ready), 32'd0);
    chk(rsp_rdata === {DEV, VEN}, "R9 R3 stalled data", rsp_rdata, {DEV, VEN});
    req_valid = 1; req_offset = 8'd8;
    repeat (3) begin
      @(negedge clk);
      chk(rsp_valid === 1 && rsp_rdata === {DEV, VEN}, "R9 held response", rsp_rdata, {DEV, VEN});
    end
    req_valid = 0;
    rsp_ready = 1;
    @(negedge clk);
    chk(rsp_valid === 0, "R9 response drains", 32'(rsp_valid), 32'd0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule